// File: doc/BRIEF.md
# Threshold Comparator Interrupt Generator

This block watches the results of a four-input multiplexed 10-bit converter. Each result arrives as a channel number, a 10-bit value and a one-cycle valid strobe. The block holds an 8-bit reference level for every channel. It compares the upper eight bits of each new result with the reference of that result's channel. The test is either "above the reference" or "at or below the reference", chosen by a direction bit per channel. A result that passes its channel's test sets a sticky flag for that channel.

The host configures references, enables and directions through a small write port. It reads the flags through a read strobe, and that read clears them. The interrupt line is active low and open-drain in style. The block gives a constant-zero data value and an output enable. Several devices can therefore share one pulled-up line. The enable is asserted while any flag whose channel is enabled is set.

Interrupt control is a two-state machine. `IRQ_RELEASED` means the line is not driven. `IRQ_PULLING` means the line is pulled to 0. Two transitions are named:
- `IRQ_RELEASED -> IRQ_PULLING`: taken when the registered flags ANDed with the enables are nonzero.
- `IRQ_PULLING -> IRQ_RELEASED`: taken when that AND is zero.

Top module: `thr_irq_gen`

## Requirements
- R1: After reset, all flags read 0, `irq_oe_o` is 0, every reference is 0, every enable is 0 and every direction bit is 0.
- R2: A write with `host_addr` 0..3 loads `host_wdata` into the reference of the channel with that number. A write to address 4 loads enables from `host_wdata[3:0]`, and address 5 loads directions from `host_wdata[3:0]`, with bit n belonging to channel n. The new value takes effect on results presented from the next cycle onward.
- R3: With direction bit 0, a valid result sets its channel's flag, one cycle later, when `res_data[9:2]` is strictly greater than that channel's reference.
- R4: With direction bit 1, a valid result sets its channel's flag, one cycle later, when `res_data[9:2]` is less than or equal to that channel's reference.
- R5: A result changes only the flag of the channel named by `res_chan`. A cycle with `res_valid` low sets no flag.
- R6: Flags are sticky. A set flag stays set until a flag read.
- R7: `flag_rdata_o[3:0]` shows the flags, bit n for channel n. A cycle with `flag_rd` high clears all flags at the next edge. A flag set by a result in that same cycle is kept set.
- R8: `irq_oe_o` rises one cycle after the flags ANDed with the enables become nonzero. `irq_n_o` is always 0.
- R9: A flag whose enable is 0 does not assert `irq_oe_o`. `irq_oe_o` falls one cycle after the flags ANDed with the enables become zero.
- R10: Writes to addresses 6 and 7 change no reference, enable or direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | 2 | Channel of the result |
| res_data | input | 10 | Conversion result |
| host_wr | input | 1 | Configuration write strobe |
| host_addr | input | 3 | Configuration address |
| host_wdata | input | 8 | Configuration write data |
| flag_rd | input | 1 | Flag read strobe; clears the flags |
| flag_rdata_o | output | 4 | Current flags |
| irq_oe_o | output | 1 | Interrupt line drive enable |
| irq_n_o | output | 1 | Interrupt line data value, constant 0 |

## Verification
Most faults inside the block reach the ports within a cycle or two:
- A corrupted reference, enable or direction bit causes the next result on that channel to give the wrong flag, and `flag_rdata_o` shows it one cycle after the result.
- A stuck interrupt state gives a wrong `irq_oe_o` one cycle after the enabled-flag set changes.

The bench keeps a behavioural model and compares both outputs on every clock. A divergence is therefore reported in the cycle it first becomes visible. Directed phases place results exactly on each reference boundary and put a set in the same cycle as a read. Random traffic then mixes writes, reads and results.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int NCH   = 4;
    localparam int RES_W = 10;
    localparam int REF_W = 8;
    localparam int ADR_W = 3;
    localparam int CH_W  = $clog2(NCH);
    localparam int EN_ADDR  = NCH;
    localparam int DIR_ADDR = NCH + 1;

    typedef enum logic {
        IRQ_RELEASED = 1'b0,
        IRQ_PULLING  = 1'b1
    } irq_state_e;
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
    import thr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr,
    input  logic [ADR_W-1:0]           host_addr,
    input  logic [REF_W-1:0]           host_wdata,
    output logic [NCH-1:0][REF_W-1:0]  refs_o,
    output logic [NCH-1:0]             en_o,
    output logic [NCH-1:0]             dir_o
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ref
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                refs_o[ch] <= '0;
            else if (host_wr && host_addr == ADR_W'(ch))
                refs_o[ch] <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o  <= '0;
            dir_o <= '0;
        end else if (host_wr) begin
            if (host_addr == ADR_W'(EN_ADDR))
                en_o <= host_wdata[NCH-1:0];
            if (host_addr == ADR_W'(DIR_ADDR))
                dir_o <= host_wdata[NCH-1:0];
        end
    end
endmodule

// File: rtl/thr_compare.sv
module thr_compare
    import thr_pkg::*;
(
    input  logic                       res_valid,
    input  logic [CH_W-1:0]            res_chan,
    input  logic [RES_W-1:0]           res_data,
    input  logic [NCH-1:0][REF_W-1:0]  refs_i,
    input  logic [NCH-1:0]             dir_i,
    output logic [NCH-1:0]             hit_o
);
    localparam int DROP = RES_W - REF_W;
    logic [REF_W-1:0] upper;
    assign upper = res_data[RES_W-1:DROP];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
        logic above;
        assign above = upper > refs_i[ch];
        assign hit_o[ch] = res_valid && (res_chan == CH_W'(ch))
                           && (dir_i[ch] ? !above : above);
    end
endmodule

// File: rtl/thr_irq_fsm.sv
module thr_irq_fsm
    import thr_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit_i,
    input  logic [NCH-1:0] en_i,
    input  logic           flag_rd,
    output logic [NCH-1:0] flags_o,
    output logic           irq_oe_o
);
    irq_state_e state_q, state_d;
    logic       pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_o <= '0;
        else
            flags_o <= (flag_rd ? '0 : flags_o) | hit_i;
    end

    assign pending = |(flags_o & en_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_RELEASED: if (pending)  state_d = IRQ_PULLING;
            IRQ_PULLING:  if (!pending) state_d = IRQ_RELEASED;
            default:      state_d = IRQ_RELEASED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_RELEASED;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_oe_o = (state_q == IRQ_PULLING);
    end

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_rd |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd |=> (flags_o == $past(hit_i)));
endmodule

// File: rtl/thr_irq_gen.sv
module thr_irq_gen
    import thr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                res_valid,
    input  logic [CH_W-1:0]     res_chan,
    input  logic [RES_W-1:0]    res_data,
    input  logic                host_wr,
    input  logic [ADR_W-1:0]    host_addr,
    input  logic [REF_W-1:0]    host_wdata,
    input  logic                flag_rd,
    output logic [NCH-1:0]      flag_rdata_o,
    output logic                irq_oe_o,
    output logic                irq_n_o
);
    logic [NCH-1:0][REF_W-1:0] refs;
    logic [NCH-1:0]            en, dir, hit, flags;

    thr_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .refs_o(refs), .en_o(en), .dir_o(dir)
    );

    thr_compare u_cmp (
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
        .refs_i(refs), .dir_i(dir), .hit_o(hit)
    );

    thr_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .en_i(en), .flag_rd(flag_rd),
        .flags_o(flags), .irq_oe_o(irq_oe_o)
    );

    assign flag_rdata_o = flags;
    assign irq_n_o      = 1'b0;

    a_r8_assert_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & en)) |=> irq_oe_o);
    a_r9_release_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flags & en)) |=> !irq_oe_o);
    a_r5_no_valid_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !flag_rd) |=> $stable(flags));
    a_r5_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    a_r8_drive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == 1'b0);
endmodule

// File: tb/sim_thr_irq_gen.sv
module sim_thr_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_valid = 1'b0;
    logic [1:0] res_chan = '0;
    logic [9:0] res_data = '0;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       flag_rd = 1'b0;
    logic [3:0] flag_rdata_o;
    logic       irq_oe_o, irq_n_o;

    int checks = 0;
    int failures = 0;
    string phase = "R1";
    bit finished = 1'b0;

    int   m_ref [4];
    logic [3:0] m_en, m_dir, m_flags;
    logic m_irq;

    always #4 clk = ~clk;

    thr_irq_gen u0 (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .flag_rd(flag_rd), .flag_rdata_o(flag_rdata_o),
        .irq_oe_o(irq_oe_o), .irq_n_o(irq_n_o)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_ref[i]) m_ref[i] = 0;
            m_en = '0; m_dir = '0; m_flags = '0; m_irq = 1'b0;
        end else begin
            logic [3:0] hits;
            int upper;
            hits = '0;
            upper = int'(res_data) / 4;
            if (res_valid) begin
                if (m_dir[res_chan] == 1'b0 && upper > m_ref[res_chan]) hits[res_chan] = 1'b1;
                if (m_dir[res_chan] == 1'b1 && upper <= m_ref[res_chan]) hits[res_chan] = 1'b1;
            end
            m_irq = (m_flags & m_en) != 0;
            m_flags = (flag_rd ? 4'b0 : m_flags) | hits;
            if (host_wr) begin
                if (host_addr < 4) m_ref[host_addr] = int'(host_wdata);
                else if (host_addr == 4) m_en = host_wdata[3:0];
                else if (host_addr == 5) m_dir = host_wdata[3:0];
            end
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            check(phase, int'(flag_rdata_o), int'(m_flags), "flags");
            check(phase, int'(irq_oe_o), int'(m_irq), "irq_oe");
            check("R8", int'(irq_n_o), 0, "irq_n");
        end
    end

    task automatic idle();
        @(negedge clk);
        res_valid = 0; host_wr = 0; flag_rd = 0;
    endtask
    task automatic wr(int a, int d);
        @(negedge clk);
        res_valid = 0; flag_rd = 0;
        host_wr = 1; host_addr = 3'(a); host_wdata = 8'(d);
    endtask
    task automatic send(int ch, int d, bit rd = 0);
        @(negedge clk);
        host_wr = 0; flag_rd = rd;
        res_valid = 1; res_chan = 2'(ch); res_data = 10'(d);
    endtask
    task automatic rd();
        @(negedge clk);
        host_wr = 0; res_valid = 0; flag_rd = 1;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle(); idle();
        @(negedge clk);
        check("R1", int'(flag_rdata_o), 0, "flags after reset");
        check("R1", int'(irq_oe_o), 0, "irq after reset");
        // R1: zero references, dir 0 -> upper 1 > 0 sets flag
        phase = "R1";
        send(3, 4); idle(); idle();
        rd(); idle();
        // R2: program references, enables, directions
        phase = "R2";
        wr(0, 8'h80); wr(1, 8'h40); wr(2, 8'h10); wr(3, 8'hF0);
        wr(4, 4'hF); wr(5, 4'b0010); idle();
        // R3: strict above, boundary
        phase = "R3";
        send(0, 10'h200); idle(); idle();
        send(0, 10'h203); idle();
        send(0, 10'h204); idle(); idle();
        @(negedge clk);
        check("R3", int'(flag_rdata_o[0]), 1, "ch0 flag above ref");
        // R4: at or below
        phase = "R4";
        rd(); idle();
        send(1, 10'h104); idle();
        send(1, 10'h103); idle();
        send(1, 10'h000); idle(); idle();
        // R5: other channels untouched, no valid
        phase = "R5";
        rd(); idle();
        @(negedge clk);
        res_valid = 0; res_chan = 2; res_data = 10'h3FF; idle();
        send(2, 10'h3FF); idle();
        // R6: stays set
        phase = "R6";
        repeat (5) idle();
        // R7: clear and set-wins
        phase = "R7";
        send(2, 10'h3FF, 1); idle();
        @(negedge clk);
        check("R7", int'(flag_rdata_o), 4'b0100, "set wins over read");
        rd(); idle();
        // R9: disabled flag does not drive
        phase = "R9";
        wr(4, 4'b0001); send(2, 10'h3FF); idle(); idle();
        check("R9", int'(irq_oe_o), 0, "disabled ch2");
        send(0, 10'h3FF); idle(); idle();
        rd(); idle(); idle();
        // R10: unused addresses
        phase = "R10";
        wr(6, 8'hFF); wr(7, 8'h00); idle();
        send(0, 10'h3FF); idle(); idle();
        send(1, 10'h000); idle();
        rd(); idle();
        // R8: random mix
        phase = "R8";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            res_valid = 1'($urandom);
            res_chan  = 2'($urandom);
            res_data  = 10'($urandom);
            flag_rd   = ($urandom % 6) == 0;
            host_wr   = ($urandom % 8) == 0;
            host_addr = 3'($urandom);
            host_wdata = 8'($urandom);
        end
        idle(); idle(); idle();
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule